// File: doc/BRIEF.md
# Framed Serial Conversion-Word Read Port

This block is the device-side read path of a converter. Each time a conversion finishes, it takes the signed result and two status conditions, builds a 24-bit frame, and holds that frame until a host reads it. The host selects the port with an active-low select line and clocks the frame out with its own serial clock on a single data line. Both the select and the serial clock are sampled by the block's system clock. The serial clock idles low.

There is no separate ready pin. The data line falls low to show that a word is waiting, and that low level is also the first bit of the frame. Bits move out most significant first. A bit changes only after a falling edge of the serial clock, so the host can sample on each rising edge. A word is never overwritten while it is being shifted out. A word is dropped if the host aborts the read. A word that nobody reads is withdrawn a fixed number of cycles before the next one is due, so that the next word brings a fresh falling edge.

Top module: `conv_word_port`

## Requirements
- R1: `sdo_oe` is high exactly when `cs_n` is low, in the same cycle, so the line floats whenever the port is deselected.
- R2: While `cs_n` is low and a word is held, `sdo` goes to 0 one clock after the word is held or the select falls. This is the ready indication and also frame bit 23.
- R3: Frame layout: bit 23 = 0, bit 22 = overrange, bit 21 = oscillation, bit 20 = 0. With DATA_W = 20, bits 19..0 are the two's-complement result. With DATA_W = 16, bits 19..16 are 0 and bits 15..0 hold the result.
- R4: Bits leave most significant first. The first rising edge of `sclk` after ready samples bit 23. Each falling edge of `sclk` presents the next lower bit one clock later, and `sdo` changes at no other time during a read.
- R5: After the falling edge that follows bit 0, `sdo` is 1 while `cs_n` is low, until a new word is held.
- R6: A `conv_done` that arrives while a frame is being shifted is discarded. The frame in flight is unchanged, and no word is pending when the read ends.
- R7: If `cs_n` rises during a read, the word is lost. When the port is selected again, `sdo` is 1 until the next conversion.
- R8: A word that is shown as ready but never clocked is withdrawn when CONV_PERIOD-WARN_LEAD clocks have passed since the last `conv_done`. `sdo` rises, and it falls again when the next word is held.
- R9: The overrange bit is set when `conv_ovr` is high or the result had to be clipped. It is set or cleared for each word on its own.
- R10: The oscillation bit is set for a word taken with `conv_osc` high. It stays set for the next OSC_HOLD words after the condition ends, and it is clear from the word after those.
- R11: Results above the largest code for DATA_W are clipped to 0x7FFFF (20-bit) or 0x7FFF (16-bit). Results below the most negative code are clipped to 0x80000 or 0x8000.
- R12: After reset no word is held, and a selected port drives `sdo` = 1.
- R13: A new `conv_done` that arrives while the held word has not started shifting replaces that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | One-cycle strobe: a conversion result is valid |
| conv_result | input | IN_W | Signed conversion result |
| conv_ovr | input | 1 | Overrange condition for this result |
| conv_osc | input | 1 | Oscillation condition for this result |
| cs_n | input | 1 | Active-low port select |
| sclk | input | 1 | Host serial clock, sampled by `clk` |
| sdo | output | 1 | Serial data value |
| sdo_oe | output | 1 | Drive enable for the data pad |

## Verification
The bench builds two copies of the port from the same stimulus. One uses a 20-bit result and the other a 16-bit result, so that a single input value shows the 20-bit pass-through and the 16-bit clipping side by side. CONV_PERIOD is set to 300 with WARN_LEAD at 17, which brings the withdrawal of an unread word within a few hundred cycles. OSC_HOLD stays at 4, so the full hold sequence of the oscillation flag and its release fits in six reads.

// File: rtl/conv_word_pkg.sv
package conv_word_pkg;

  localparam int FRAME_W = 24;
  localparam int CODE_W  = 20;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READY = 2'd1,
    PH_SHIFT = 2'd2
  } port_phase_t;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic              clip;
  } sat_t;

  // Clip a signed value to dw bits and return it zero-padded to CODE_W bits.
  function automatic sat_t saturate_code(input logic signed [31:0] v, input int dw);
    logic signed [31:0] hi;
    logic signed [31:0] lo;
    logic [31:0]        msk;
    logic [31:0]        raw;
    sat_t               r;
    hi  = (32'sd1 <<< (dw - 1)) - 32'sd1;
    lo  = -(32'sd1 <<< (dw - 1));
    msk = (32'd1 << dw) - 32'd1;
    if (v > hi) begin
      raw    = hi;
      r.clip = 1'b1;
    end else if (v < lo) begin
      raw    = lo;
      r.clip = 1'b1;
    end else begin
      raw    = v;
      r.clip = 1'b0;
    end
    r.code = CODE_W'(raw & msk);
    return r;
  endfunction

  function automatic logic [FRAME_W-1:0] pack_frame(input logic ovr, input logic osc,
                                                    input logic [CODE_W-1:0] code);
    return {1'b0, ovr, osc, 1'b0, code};
  endfunction

endpackage

// File: rtl/conv_word_frame_build.sv
module conv_word_frame_build
  import conv_word_pkg::*;
#(
  parameter int IN_W     = 24,
  parameter int DATA_W   = 20,
  parameter int OSC_HOLD = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               conv_done,
  input  logic [IN_W-1:0]    conv_result,
  input  logic               conv_ovr,
  input  logic               conv_osc,
  output logic [FRAME_W-1:0] frame
);

  localparam int HOLD_W = $clog2(OSC_HOLD + 1);
  localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(OSC_HOLD);

  logic signed [31:0] res_ext;
  sat_t               sat;
  logic [HOLD_W-1:0]  osc_left;
  logic               osc_flag;

  assign res_ext  = {{(32-IN_W){conv_result[IN_W-1]}}, conv_result};
  assign sat      = saturate_code(res_ext, DATA_W);
  assign osc_flag = conv_osc | (osc_left != '0);
  assign frame    = pack_frame(conv_ovr | sat.clip, osc_flag, sat.code);

  // Oscillation hold counter advances once per finished conversion.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_left <= '0;
    end else if (conv_done) begin
      if (conv_osc)             osc_left <= HOLD_LOAD;
      else if (osc_left != '0)  osc_left <= osc_left - 1'b1;
    end
  end

  assert_osc_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && conv_osc) |=> (!conv_done || osc_flag));

endmodule

// File: rtl/conv_word_sclk_edge.sv
module conv_word_sclk_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  output logic rise,
  output logic fall
);

  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  assign rise = sclk & ~sclk_q;
  assign fall = ~sclk & sclk_q;

endmodule

// File: rtl/conv_word_shift_ctrl.sv
module conv_word_shift_ctrl
  import conv_word_pkg::*;
#(
  parameter int CONV_PERIOD = 612,
  parameter int WARN_LEAD   = 17
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               rise,
  input  logic               fall,
  input  logic               conv_done,
  input  logic [FRAME_W-1:0] frame_in,
  output logic               sdo_bit
);

  localparam int IDX_W    = $clog2(FRAME_W);
  localparam int CNT_W    = $clog2(CONV_PERIOD + 1);
  localparam int DROP_INT = (CONV_PERIOD > WARN_LEAD) ? (CONV_PERIOD - WARN_LEAD - 1) : 0;
  localparam logic [CNT_W-1:0] DROP_CNT = CNT_W'(DROP_INT);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(CONV_PERIOD);
  localparam logic [IDX_W-1:0] TOP_IDX  = IDX_W'(FRAME_W - 1);

  port_phase_t        phase, phase_nx;
  logic               pending, pending_nx;
  logic [IDX_W-1:0]   idx, idx_nx;
  logic [FRAME_W-1:0] word_q;
  logic [CNT_W-1:0]   since_cnt;

  // Named events for the next-state logic and the assertions.
  logic load_evt, abort_evt, done_evt, drop_evt, start_evt;
  assign load_evt  = conv_done && (phase != PH_SHIFT);
  assign abort_evt = cs_n && (phase == PH_SHIFT);
  assign done_evt  = !cs_n && (phase == PH_SHIFT) && fall && (idx == '0);
  assign start_evt = !cs_n && (phase == PH_READY) && rise;
  assign drop_evt  = !cs_n && (phase == PH_READY) && !rise && (since_cnt == DROP_CNT);

  always_comb begin
    phase_nx   = phase;
    pending_nx = pending;
    idx_nx     = idx;
    if (cs_n) begin
      phase_nx = PH_IDLE;
      if (abort_evt) pending_nx = 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE:  if (pending) phase_nx = PH_READY;
        PH_READY: begin
          if (start_evt) begin
            phase_nx = PH_SHIFT;
            idx_nx   = TOP_IDX;
          end else if (drop_evt) begin
            phase_nx   = PH_IDLE;
            pending_nx = 1'b0;
          end
        end
        PH_SHIFT: begin
          if (done_evt) begin
            phase_nx   = PH_IDLE;
            pending_nx = 1'b0;
          end else if (fall) begin
            idx_nx = idx - 1'b1;
          end
        end
        default:  phase_nx = PH_IDLE;
      endcase
    end
    if (load_evt) pending_nx = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      pending   <= 1'b0;
      idx       <= '0;
      word_q    <= '0;
      since_cnt <= '0;
    end else begin
      phase   <= phase_nx;
      pending <= pending_nx;
      idx     <= idx_nx;
      if (load_evt) word_q <= frame_in;
      if (conv_done)              since_cnt <= '0;
      else if (since_cnt != CNT_MAX) since_cnt <= since_cnt + 1'b1;
    end
  end

  always_comb begin
    unique case (phase)
      PH_READY: sdo_bit = 1'b0;
      PH_SHIFT: sdo_bit = word_q[idx];
      default:  sdo_bit = 1'b1;
    endcase
  end

  assert_ready_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && phase == PH_IDLE && pending) |=> (phase == PH_READY));

  assert_bit_moves_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && phase == PH_SHIFT && !fall) |=> (phase == PH_SHIFT && $stable(idx)));

  assert_frame_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (phase == PH_IDLE && !pending));

  assert_no_update_in_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SHIFT) |=> $stable(word_q));

  assert_abort_loses_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (phase == PH_IDLE && !pending));

  assert_unread_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_evt && !conv_done) |=> (!pending && phase == PH_IDLE));

endmodule

// File: rtl/conv_word_port.sv
module conv_word_port
  import conv_word_pkg::*;
#(
  parameter int IN_W        = 24,
  parameter int DATA_W      = 20,
  parameter int OSC_HOLD    = 4,
  parameter int CONV_PERIOD = 612,
  parameter int WARN_LEAD   = 17
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            conv_done,
  input  logic [IN_W-1:0] conv_result,
  input  logic            conv_ovr,
  input  logic            conv_osc,
  input  logic            cs_n,
  input  logic            sclk,
  output logic            sdo,
  output logic            sdo_oe
);

  logic [FRAME_W-1:0] frame;
  logic               sclk_rise;
  logic               sclk_fall;

  conv_word_frame_build #(
    .IN_W     (IN_W),
    .DATA_W   (DATA_W),
    .OSC_HOLD (OSC_HOLD)
  ) u_build (
    .clk         (clk),
    .rst_n       (rst_n),
    .conv_done   (conv_done),
    .conv_result (conv_result),
    .conv_ovr    (conv_ovr),
    .conv_osc    (conv_osc),
    .frame       (frame)
  );

  conv_word_sclk_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .sclk  (sclk),
    .rise  (sclk_rise),
    .fall  (sclk_fall)
  );

  conv_word_shift_ctrl #(
    .CONV_PERIOD (CONV_PERIOD),
    .WARN_LEAD   (WARN_LEAD)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .rise      (sclk_rise),
    .fall      (sclk_fall),
    .conv_done (conv_done),
    .frame_in  (frame),
    .sdo_bit   (sdo)
  );

  assign sdo_oe = ~cs_n;

endmodule

// File: tb/conv_word_port_test.sv
`timescale 1ns/1ps
module conv_word_port_test;

  localparam int P_PERIOD = 300;
  localparam int P_LEAD   = 17;
  localparam int P_HOLD   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_done = 1'b0;
  logic [23:0] conv_result = '0;
  logic        conv_ovr = 1'b0;
  logic        conv_osc = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic        sdo, sdo_oe, sdo16, sdo_oe16;

  int checks = 0;
  int errors = 0;
  bit wd_fired = 0;
  string cur_tag = "R12";

  always #2.5 clk = ~clk;

  conv_word_port #(.IN_W(24), .DATA_W(20), .OSC_HOLD(P_HOLD),
                   .CONV_PERIOD(P_PERIOD), .WARN_LEAD(P_LEAD)) uut (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_result(conv_result),
    .conv_ovr(conv_ovr), .conv_osc(conv_osc), .cs_n(cs_n), .sclk(sclk),
    .sdo(sdo), .sdo_oe(sdo_oe));

  conv_word_port #(.IN_W(24), .DATA_W(16), .OSC_HOLD(P_HOLD),
                   .CONV_PERIOD(P_PERIOD), .WARN_LEAD(P_LEAD)) uut16 (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_result(conv_result),
    .conv_ovr(conv_ovr), .conv_osc(conv_osc), .cs_n(cs_n), .sclk(sclk),
    .sdo(sdo16), .sdo_oe(sdo_oe16));

  task automatic note(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Expected frame from the requirements (R3, R9, R10, R11), integer arithmetic.
  function automatic logic [23:0] expect_frame(int w, int res, bit ovr, bit oscf);
    int top = (1 << (w - 1)) - 1;
    int bot = -(1 << (w - 1));
    int v = res;
    bit c = 0;
    logic [23:0] f;
    if (v > top) begin v = top; c = 1; end
    if (v < bot) begin v = bot; c = 1; end
    f = 24'(v) & 24'((1 << w) - 1);
    f[22] = ovr | c;
    f[21] = oscf;
    return f;
  endfunction

  // Behavioural reference model, advanced on every clock.
  int          m_phase = 0;   // 0 none shown, 1 ready shown, 2 shifting
  bit          m_have = 0;
  int          m_bit = 0;
  int          m_since = 0;
  int          m_osc_left = 0;
  bit          m_sclk_q = 0;
  logic [23:0] m_w20 = '0, m_w16 = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_have = 0; m_bit = 0; m_since = 0;
      m_osc_left = 0; m_sclk_q = 0; m_w20 = '0; m_w16 = '0;
    end else begin
      bit rise_s, fall_s, of;
      int nph;
      bit nhave;
      rise_s = sclk && !m_sclk_q;
      fall_s = !sclk && m_sclk_q;
      nph = m_phase;
      nhave = m_have;
      if (cs_n) begin
        if (m_phase == 2) nhave = 0;
        nph = 0;
      end else if (m_phase == 0) begin
        if (m_have) nph = 1;
      end else if (m_phase == 1) begin
        if (rise_s) begin nph = 2; m_bit = 23; end
        else if (m_since == P_PERIOD - P_LEAD - 1) begin nph = 0; nhave = 0; end
      end else begin
        if (fall_s) begin
          if (m_bit == 0) begin nph = 0; nhave = 0; end
          else m_bit = m_bit - 1;
        end
      end
      if (conv_done) begin
        of = conv_osc || (m_osc_left > 0);
        if (m_phase != 2) begin
          m_w20 = expect_frame(20, int'($signed(conv_result)), conv_ovr, of);
          m_w16 = expect_frame(16, int'($signed(conv_result)), conv_ovr, of);
          nhave = 1;
        end
        if (conv_osc) m_osc_left = P_HOLD;
        else if (m_osc_left > 0) m_osc_left--;
        m_since = 0;
      end else if (m_since < P_PERIOD) begin
        m_since++;
      end
      m_phase = nph;
      m_have = nhave;
      m_sclk_q = sclk;
    end
  end

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !wd_fired) begin
      logic e20, e16;
      e20 = (m_phase == 1) ? 1'b0 : (m_phase == 2) ? m_w20[m_bit] : 1'b1;
      e16 = (m_phase == 1) ? 1'b0 : (m_phase == 2) ? m_w16[m_bit] : 1'b1;
      note(sdo_oe === !cs_n && sdo_oe16 === !cs_n, "R1", "sdo_oe vs select",
           {31'b0, sdo_oe}, {31'b0, !cs_n});
      if (!cs_n) begin
        note(sdo === e20, cur_tag, "sdo 20-bit vs model", {31'b0, sdo}, {31'b0, e20});
        note(sdo16 === e16, cur_tag, "sdo 16-bit vs model", {31'b0, sdo16}, {31'b0, e16});
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic pulse_conv(input int res, input bit ovr, input bit osc);
    conv_result = 24'(res);
    conv_ovr = ovr;
    conv_osc = osc;
    conv_done = 1'b1;
    tick(1);
    conv_done = 1'b0;
    conv_ovr = 1'b0;
    conv_osc = 1'b0;
  endtask

  task automatic sample_expect(input logic exp, input string tag, input string what);
    @(negedge clk);
    note(sdo === exp && sdo16 === exp, tag, what, {30'b0, sdo, sdo16}, {30'b0, exp, exp});
    @(posedge clk); #1;
  endtask

  task automatic wait_ready(input string tag);
    bit seen = 0;
    for (int n = 0; n < 20 && !seen; n++) begin
      @(negedge clk);
      if (sdo === 1'b0 && sdo16 === 1'b0) seen = 1;
    end
    note(seen, tag, "ready low seen", {31'b0, seen}, 32'd1);
    @(posedge clk); #1;
  endtask

  task automatic read_frame(input int inj_at, input int inj_res, input int abort_at,
                            output logic [23:0] r20, output logic [23:0] r16);
    r20 = '0;
    r16 = '0;
    for (int i = 0; i < 24; i++) begin
      if (i == abort_at) begin
        cs_n = 1'b1;
        tick(1);
        return;
      end
      sclk = 1'b1;
      if (i == inj_at) pulse_conv(inj_res, 1'b0, 1'b0);
      else tick(1);
      @(negedge clk);
      r20[23-i] = sdo;
      r16[23-i] = sdo16;
      @(posedge clk); #1;
      sclk = 1'b0;
      tick(2);
    end
  endtask

  task automatic read_and_check(input string tag, input logic [23:0] x20,
                                input logic [23:0] x16);
    logic [23:0] g20, g16;
    wait_ready(tag);
    read_frame(-1, 0, -1, g20, g16);
    note(g20 === x20, tag, "20-bit frame", {8'b0, g20}, {8'b0, x20});
    note(g16 === x16, tag, "16-bit frame", {8'b0, g16}, {8'b0, x16});
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    wd_fired = 1;
    checks++;
    errors++;
    $display("FAIL watchdog R12 actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [23:0] g20, g16;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R12: reset state, no word held.
    cur_tag = "R12";
    @(negedge clk);
    note(sdo_oe === 1'b0 && sdo_oe16 === 1'b0, "R1", "deselected enable", {31'b0, sdo_oe}, 32'd0);
    @(posedge clk); #1;
    cs_n = 1'b0;
    sample_expect(1'b1, "R12", "idle line after reset");

    // R3, R4, R11, R9: positive value, clipped only at 16 bits.
    cur_tag = "R4";
    pulse_conv(32'h12345, 1'b0, 1'b0);
    read_and_check("R11", 24'h012345, 24'h407FFF);
    sample_expect(1'b1, "R5", "line high after frame");
    tick(4);
    sample_expect(1'b1, "R5", "line stays high");

    cur_tag = "R3";
    pulse_conv(-5, 1'b0, 1'b0);
    read_and_check("R3", 24'h0FFFFB, 24'h00FFFB);
    pulse_conv(-32'h90000, 1'b0, 1'b0);
    read_and_check("R11", 24'h480000, 24'h408000);
    cur_tag = "R9";
    pulse_conv(32'h00100, 1'b1, 1'b0);
    read_and_check("R9", 24'h400100, 24'h400100);
    pulse_conv(32'h00100, 1'b0, 1'b0);
    read_and_check("R9", 24'h000100, 24'h000100);

    // R10: oscillation flag hold.
    cur_tag = "R10";
    pulse_conv(32'h00ABC, 1'b0, 1'b1);
    read_and_check("R10", 24'h200ABC, 24'h200ABC);
    for (int k = 0; k < P_HOLD; k++) begin
      pulse_conv(32'h00ABC, 1'b0, 1'b0);
      read_and_check("R10", 24'h200ABC, 24'h200ABC);
    end
    pulse_conv(32'h00ABC, 1'b0, 1'b0);
    read_and_check("R10", 24'h000ABC, 24'h000ABC);

    // R6: conversion arriving mid-read is discarded.
    cur_tag = "R6";
    pulse_conv(32'h00111, 1'b0, 1'b0);
    wait_ready("R6");
    read_frame(10, 32'h00222, -1, g20, g16);
    note(g20 === 24'h000111, "R6", "frame kept during read", {8'b0, g20}, 32'h000111);
    tick(8);
    sample_expect(1'b1, "R6", "no pending word after discard");
    pulse_conv(32'h00333, 1'b0, 1'b0);
    read_and_check("R6", 24'h000333, 24'h000333);

    // R7: select raised during a read.
    cur_tag = "R7";
    pulse_conv(32'h00444, 1'b0, 1'b0);
    wait_ready("R7");
    read_frame(-1, 0, 5, g20, g16);
    tick(3);
    cs_n = 1'b0;
    tick(2);
    sample_expect(1'b1, "R7", "aborted word gone");
    pulse_conv(32'h00555, 1'b0, 1'b0);
    read_and_check("R7", 24'h000555, 24'h000555);

    // R13: newer word replaces an unread one.
    cur_tag = "R13";
    cs_n = 1'b1;
    pulse_conv(32'h00666, 1'b0, 1'b0);
    tick(2);
    pulse_conv(32'h00777, 1'b0, 1'b0);
    tick(2);
    cs_n = 1'b0;
    read_and_check("R13", 24'h000777, 24'h000777);

    // R8: unread word withdrawn ahead of the next conversion.
    cur_tag = "R8";
    pulse_conv(32'h00888, 1'b0, 1'b0);
    tick(P_PERIOD - P_LEAD - 3);
    sample_expect(1'b0, "R8", "still ready before lead window");
    tick(2);
    sample_expect(1'b1, "R8", "line raised in lead window");
    tick(P_LEAD - 2);
    pulse_conv(32'h00999, 1'b0, 1'b0);
    read_and_check("R8", 24'h000999, 24'h000999);

    // R1: deselect floats the line.
    cs_n = 1'b1;
    tick(1);
    @(negedge clk);
    note(sdo_oe === 1'b0 && sdo_oe16 === 1'b0, "R1", "enable off when deselected",
         {31'b0, sdo_oe}, 32'd0);
    tick(2);
    summary();
    $finish;
  end

endmodule